// File: doc/BRIEF.md
# Gear-Down Command Phase Aligner

This block sits at the receiving end of a DDR4-style command, address and control bus. It decides which rising clock edges carry a valid command. After reset it captures a command on every rising edge where chip select is low. It watches for a mode-register-set command aimed at mode register 3 with the gear-down bit set. When it sees that command, it stops forwarding commands and waits for a sync pulse. A sync pulse is chip select held low for exactly one clock cycle.

The edge on which the sync pulse is seen becomes the phase reference. From then on the block samples only every second rising edge, counted from that edge. The bus clock frequency does not change; only the command rate is halved. A command accepted on an edge appears on the outputs after that edge as a one-cycle valid strobe, together with the captured command code, bank-group bit, bank address and address.

Top module: `gd_cmd_aligner`

## Requirements
- R1: While reset is asserted and right after it, `mode` reads 0 (normal) and `cmd_vld` is 0.
- R2: In normal mode (`mode`=0), every rising edge with `cs_n`=0 produces `cmd_vld`=1 for one cycle after that edge. At the same time `cmd_bits`={act_n,ras_n,cas_n,we_n}, `cmd_bg0`, `cmd_ba` and `cmd_addr` show the values sampled on that edge. An edge with `cs_n`=1 gives `cmd_vld`=0.
- R3: A mode-register-set command is `cs_n`=0, `act_n`=1, `ras_n`=`cas_n`=`we_n`=0. It selects mode register 3 when `bg0`=0 and `ba`=2'b11. Only such a command with `addr[3]`=1, seen in normal mode, moves `mode` to 1 (waiting for sync). Any other register, bank group or bit value leaves `mode` at 0.
- R4: While `mode`=1, no command is forwarded (`cmd_vld` stays 0).
- R5: While `mode`=1, an edge with `cs_n`=0 that has `cs_n`=1 on the edge before and the edge after is a sync pulse. `mode` reads 2 (gear-down) after the edge that follows the pulse.
- R6: A `cs_n` low lasting two or more edges is not a sync pulse, and neither is a low on the edge right after the mode-register write. `mode` stays 1 in both cases.
- R7: In gear-down mode, with the sync pulse on edge P, commands are accepted only on edges P+2, P+4, and so on. `cs_n`=0 on edges P+1, P+3, and so on gives no `cmd_vld`.
- R8: Gear-down mode is left only by reset. A mode-register-set command received in gear-down mode is forwarded on an accepted edge, and `mode` stays 2.
- R9: `mode` never takes the value 3 and never goes directly from 0 to 2.
- R10: Asserting `rst_n` at any time returns the block to normal mode. After release, every edge with `cs_n` low is again forwarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge used |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| act_n | input | 1 | Activate command line |
| ras_n | input | 1 | Row strobe / command line |
| cas_n | input | 1 | Column strobe / command line |
| we_n | input | 1 | Write enable / command line |
| bg0 | input | 1 | Bank-group bit 0 |
| ba | input | 2 | Bank address |
| addr | input | ADDR_W | Address bus |
| cmd_vld | output | 1 | One-cycle strobe for an accepted command |
| cmd_bits | output | 4 | Captured {act_n,ras_n,cas_n,we_n} |
| cmd_bg0 | output | 1 | Captured bank-group bit |
| cmd_ba | output | 2 | Captured bank address |
| cmd_addr | output | ADDR_W | Captured address |
| mode | output | 2 | 0 normal, 1 waiting for sync, 2 gear-down locked |

## Verification
A wrong phase toggle or a wrong sync decision shows at the ports within one or two cycles. Commands are then accepted on the odd edges instead of the even ones, or `mode` fails to reach 2 after a clean pulse, or reaches it after a long pulse. A decode error in the register or bank selection moves `mode` to 1 on the wrong write, which shows on the very next cycle. Forwarding during the wait state shows as a `cmd_vld` on an edge where none is allowed. The vector walk checks `cmd_vld` and `mode` on every single edge, so a one-edge slip in the phase is caught.

// File: rtl/gd_pkg.sv
package gd_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_WAIT   = 2'd1,
    MODE_GEAR   = 2'd2
  } gd_mode_e;

  localparam logic [3:0] MRS_CODE = 4'b1000; // act_n, ras_n, cas_n, we_n
endpackage

// File: rtl/gd_cmd_decode.sv
module gd_cmd_decode
  import gd_pkg::*;
#(
  parameter logic [1:0] MR_BA = 2'b11,
  parameter logic       MR_BG = 1'b0
) (
  input  logic       cs_n,
  input  logic [3:0] cmd,
  input  logic       bg0,
  input  logic [1:0] ba,
  input  logic       gd_bit,
  output logic       gd_req
);
  logic is_mrs;
  logic is_mr3;

  always_comb begin
    is_mrs = !cs_n && (cmd == MRS_CODE);
    is_mr3 = (bg0 == MR_BG) && (ba == MR_BA);
    gd_req = is_mrs && is_mr3 && gd_bit;
  end
endmodule

// File: rtl/gd_sync_detect.sv
module gd_sync_detect (
  input  logic clk,
  input  logic rst_ni,
  input  logic en,
  input  logic cs_n,
  output logic sync_hit
);
  logic arm_q, arm_d;
  logic cand_q, cand_d;

  always_comb begin
    if (en) begin
      arm_d  = cs_n;
      cand_d = !cs_n && arm_q;
    end else begin
      arm_d  = 1'b0;
      cand_d = 1'b0;
    end
    sync_hit = en && cs_n && cand_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= 1'b0;
      cand_q <= 1'b0;
    end else begin
      arm_q  <= arm_d;
      cand_q <= cand_d;
    end
  end
endmodule

// File: rtl/gd_phase_ctrl.sv
module gd_phase_ctrl
  import gd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_ni,
  input  logic     gd_req,
  input  logic     sync_hit,
  output gd_mode_e mode_q,
  output logic     accept
);
  gd_mode_e mode_d;
  logic     tog_q, tog_d;

  always_comb begin
    mode_d = mode_q;
    tog_d  = tog_q;
    accept = 1'b0;
    unique case (mode_q)
      MODE_NORMAL: begin
        accept = 1'b1;
        if (gd_req) mode_d = MODE_WAIT;
      end
      MODE_WAIT: begin
        if (sync_hit) begin
          mode_d = MODE_GEAR;
          tog_d  = 1'b0;
        end
      end
      MODE_GEAR: begin
        accept = !tog_q;
        tog_d  = !tog_q;
      end
      default: mode_d = MODE_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_NORMAL;
      tog_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      tog_q  <= tog_d;
    end
  end
endmodule

// File: rtl/gd_cmd_aligner.sv
module gd_cmd_aligner
  import gd_pkg::*;
#(
  parameter int         ADDR_W = 14,
  parameter int         GD_BIT = 3,
  parameter logic [1:0] MR_BA  = 2'b11,
  parameter logic       MR_BG  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              act_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              bg0,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  output logic              cmd_vld,
  output logic [3:0]        cmd_bits,
  output logic              cmd_bg0,
  output logic [1:0]        cmd_ba,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [1:0]        mode
);
  localparam int RS_STAGES = 2;

  logic [RS_STAGES-1:0] rs_q;
  logic                 rst_ni;
  logic [3:0]           cmd_in;
  logic                 gd_req;
  logic                 sync_hit;
  logic                 accept;
  logic                 take;
  gd_mode_e             mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[RS_STAGES-2:0], 1'b1};
  end
  assign rst_ni = rs_q[RS_STAGES-1];

  assign cmd_in = {act_n, ras_n, cas_n, we_n};

  gd_cmd_decode #(.MR_BA(MR_BA), .MR_BG(MR_BG)) u_dec (
    .cs_n   (cs_n),
    .cmd    (cmd_in),
    .bg0    (bg0),
    .ba     (ba),
    .gd_bit (addr[GD_BIT]),
    .gd_req (gd_req)
  );

  gd_sync_detect u_sync (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .en       (mode_q == MODE_WAIT),
    .cs_n     (cs_n),
    .sync_hit (sync_hit)
  );

  gd_phase_ctrl u_phase (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .gd_req   (gd_req),
    .sync_hit (sync_hit),
    .mode_q   (mode_q),
    .accept   (accept)
  );

  assign take = accept && !cs_n;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cmd_vld <= 1'b0;
    else         cmd_vld <= take;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_bits <= '1;
      cmd_bg0  <= 1'b0;
      cmd_ba   <= '0;
      cmd_addr <= '0;
    end else if (take) begin
      cmd_bits <= cmd_in;
      cmd_bg0  <= bg0;
      cmd_ba   <= ba;
      cmd_addr <= addr;
    end
  end

  assign mode = mode_q;
endmodule

module gd_cmd_aligner_chk
  import gd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       cmd_vld,
  input logic [1:0] mode
);
  // R2
  vld_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> !$past(cs_n));
  // R4
  wait_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_WAIT) |=> !cmd_vld);
  // R7
  gear_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_GEAR && cmd_vld) |=> !cmd_vld);
  // R8
  gear_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_GEAR) |=> (mode == MODE_GEAR));
  // R9
  no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_NORMAL) |=> (mode != MODE_GEAR));
  // R9
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);
endmodule

bind gd_cmd_aligner gd_cmd_aligner_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_n    (cs_n),
  .cmd_vld (cmd_vld),
  .mode    (mode)
);

// File: tb/gd_cmd_aligner_test.sv
`timescale 1ns/1ps
module gd_cmd_aligner_test;
  localparam int ADDR_W = 14;
  localparam int NVEC   = 21;
  localparam logic [3:0] RD  = 4'b1101;
  localparam logic [3:0] MRS = 4'b1000;
  localparam logic [3:0] NOP = 4'b1111;

  // {cs_n, cmd[3:0], bg0, ba[1:0], a3, exp_vld, exp_mode[1:0]}
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b0, RD,  1'b0, 2'b00, 1'b0, 1'b1, 2'd0},
    {1'b1, NOP, 1'b0, 2'b00, 1'b0, 1'b0, 2'd0},
    {1'b0, MRS, 1'b0, 2'b01, 1'b1, 1'b1, 2'd0},
    {1'b0, MRS, 1'b1, 2'b11, 1'b1, 1'b1, 2'd0},
    {1'b0, MRS, 1'b0, 2'b11, 1'b0, 1'b1, 2'd0},
    {1'b0, MRS, 1'b0, 2'b11, 1'b1, 1'b1, 2'd1},
    {1'b1, NOP, 1'b0, 2'b00, 1'b0, 1'b0, 2'd1},
    {1'b0, NOP, 1'b0, 2'b00, 1'b0, 1'b0, 2'd1},
    {1'b0, NOP, 1'b0, 2'b00, 1'b0, 1'b0, 2'd1},
    {1'b1, NOP, 1'b0, 2'b00, 1'b0, 1'b0, 2'd1},
    {1'b0, RD,  1'b0, 2'b00, 1'b0, 1'b0, 2'd1},
    {1'b1, NOP, 1'b0, 2'b00, 1'b0, 1'b0, 2'd2},
    {1'b0, RD,  1'b1, 2'b10, 1'b1, 1'b1, 2'd2},
    {1'b0, RD,  1'b0, 2'b01, 1'b0, 1'b0, 2'd2},
    {1'b1, NOP, 1'b0, 2'b00, 1'b0, 1'b0, 2'd2},
    {1'b0, RD,  1'b0, 2'b00, 1'b0, 1'b0, 2'd2},
    {1'b0, MRS, 1'b0, 2'b11, 1'b0, 1'b1, 2'd2},
    {1'b1, NOP, 1'b0, 2'b00, 1'b0, 1'b0, 2'd2},
    {1'b1, NOP, 1'b0, 2'b00, 1'b0, 1'b0, 2'd2},
    {1'b0, RD,  1'b0, 2'b00, 1'b0, 1'b0, 2'd2},
    {1'b0, RD,  1'b0, 2'b10, 1'b1, 1'b1, 2'd2}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cs_n, act_n, ras_n, cas_n, we_n, bg0;
  logic [1:0] ba;
  logic [ADDR_W-1:0] addr;
  logic cmd_vld, cmd_bg0;
  logic [3:0] cmd_bits;
  logic [1:0] cmd_ba, mode;
  logic [ADDR_W-1:0] cmd_addr;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  gd_cmd_aligner #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .act_n(act_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .bg0(bg0), .ba(ba), .addr(addr),
    .cmd_vld(cmd_vld), .cmd_bits(cmd_bits), .cmd_bg0(cmd_bg0),
    .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .mode(mode)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic [3:0] k, input logic b0,
                       input logic [1:0] b, input logic [ADDR_W-1:0] a);
    cs_n = c; {act_n, ras_n, cas_n, we_n} = k; bg0 = b0; ba = b; addr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(1'b1, NOP, 1'b0, 2'b00, '0);
  endtask

  initial begin
    #(200000 * 4);
    check("watchdog", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cs_n = 1'b1; {act_n, ras_n, cas_n, we_n} = NOP; bg0 = 1'b0; ba = '0; addr = '0;
    repeat (3) @(negedge clk);
    check("R1 mode in reset", mode, 0);
    check("R1 vld in reset", cmd_vld, 0);
    rst_n = 1'b1;
    idle(3);
    check("R1 mode after reset", mode, 0);
    check("R1 vld after reset", cmd_vld, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [11:0] v;
      logic [ADDR_W-1:0] a;
      string tag;
      v = VEC[i];
      a = '0;
      a[2:0] = i[2:0];
      a[3] = v[3];
      a[9:6] = i[3:0];
      drive(v[11], v[10:7], v[6], v[5:4], a);
      case (v[1:0])
        2'd0: tag = (i >= 2 && i <= 4) ? "R3" : "R2";
        2'd1: tag = (i == 5) ? "R3" : (i <= 9 ? "R6/R4" : "R5/R4");
        default: tag = (i == 11) ? "R5" : (i == 16 ? "R8" : "R7");
      endcase
      check($sformatf("%s vec%0d vld", tag, i), cmd_vld, v[2]);
      check($sformatf("%s vec%0d mode", tag, i), mode, v[1:0]);
      if (v[2]) begin
        check($sformatf("R2 vec%0d bits", i), cmd_bits, v[10:7]);
        check($sformatf("R2 vec%0d addr", i), cmd_addr, a);
        check($sformatf("R2 vec%0d bg ba", i), {cmd_bg0, cmd_ba}, v[6:4]);
      end
    end

    // R8: stays locked through idle and a mode-register write
    idle(5);
    check("R8 mode sticky", mode, 2);

    // R10: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 mode on reset", mode, 0);
    check("R10 vld on reset", cmd_vld, 0);
    rst_n = 1'b1;
    idle(3);
    drive(1'b0, RD, 1'b0, 2'b00, 14'h0011);
    check("R10 first edge vld", cmd_vld, 1);
    drive(1'b0, RD, 1'b0, 2'b00, 14'h0022);
    check("R10 next edge vld", cmd_vld, 1);
    check("R10 next edge addr", cmd_addr, 14'h0022);

    // R6: low right after the mode-register write is not a sync pulse
    drive(1'b0, MRS, 1'b0, 2'b11, 14'h0008);
    check("R3 enter wait", mode, 1);
    drive(1'b0, RD, 1'b0, 2'b00, '0);
    check("R4 no vld in wait", cmd_vld, 0);
    drive(1'b1, NOP, 1'b0, 2'b00, '0);
    check("R6 no lock after early low", mode, 1);
    // R5: clean pulse then lock
    drive(1'b0, NOP, 1'b0, 2'b00, '0);
    check("R5 pulse edge mode", mode, 1);
    drive(1'b1, NOP, 1'b0, 2'b00, '0);
    check("R5 locked", mode, 2);
    drive(1'b0, RD, 1'b0, 2'b01, 14'h0155);
    check("R7 first accepted edge", cmd_vld, 1);
    check("R7 first accepted addr", cmd_addr, 14'h0155);
    drive(1'b0, RD, 1'b0, 2'b01, 14'h0066);
    check("R7 odd edge ignored", cmd_vld, 0);
    check("R7 odd edge addr held", cmd_addr, 14'h0155);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule